// File: doc/BRIEF.md
# Micro-Operation Sequenced Accumulator Processor

This block is a small accumulator machine whose hardwired controller walks every instruction through a fixed list of register-transfer steps. Each clock is one timing slot. Each slot opens a small set of gates between the address latch, the data latch, the program counter, the instruction holder, the accumulator and two latches placed around a combinational adder. The machine moves through four major cycles: fetch, indirect (only for indirect instructions), execute and interrupt.

Memory is reached through a synchronous port. The address comes straight from the address latch. Write data comes straight from the data latch. A read strobe and a write strobe are raised in the slots that use them. An interrupt request line is honoured only when an internal enable flag is set. That flag is raised by a one-cycle pulse and is cleared by hardware when the interrupt cycle begins. Debug outputs expose the current cycle, slot, program counter, instruction and accumulator, so that each transfer can be followed slot by slot.

Top module: `uop_acc_cpu`

## Requirements
- R1: While reset is asserted and just after it is released, the machine is in cycle code 0 (fetch) at slot 1. PC equals BOOT_ADDR (default 16), AC is 0, the interrupt enable is clear, halted is low, and both memory strobes are low.
- R2: Instruction word layout: bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. Fetch takes three slots. Slot 1 loads the address latch from PC. Slot 2 raises the read strobe with mem_addr equal to PC, loads the data latch from memory and adds one to PC. Slot 3 copies the data latch into the instruction holder.
- R3: The indirect cycle (code 1) runs after fetch only when bit 15 is set, and it takes three slots. It ends with bits 11:0 of the instruction holder replaced by bits 11:0 of the word read from the pointer address. Bits 15:12 are kept.
- R4: Opcode 0 (load) takes three execute slots and leaves AC equal to the memory word at the effective address.
- R5: Opcode 1 (add) takes five execute slots and leaves AC equal to AC plus the memory word, modulo 2^16.
- R6: Opcode 2 (increment and skip) takes four execute slots. In slot 4 it writes the incremented word back. In that same slot, PC advances by one if the written word is zero.
- R7: Opcode 3 (branch and save) takes three execute slots. It stores the return PC at the effective address X and leaves PC equal to X+1.
- R8: Opcode 7 halts the machine. Halted goes high, cycle, slot and PC freeze, and no strobe is raised again. Opcodes 4, 5 and 6 finish execute in one slot and change nothing.
- R9: A pending interrupt (irq high while the enable is set) is tested only at the end of execute. It is never taken during fetch or indirect, and irq with the enable clear has no effect.
- R10: The interrupt cycle (code 3) takes three slots. It writes the old PC to address SAVE_ADDR (default 0) in slot 3 and leaves PC equal to ROUTINE_ADDR (default 1). The enable is cleared on entry. A one-cycle ien_set pulse sets the enable, and clearing wins if both happen on the same edge.
- R11: dbg_cyc reports fetch=0, indirect=1, execute=2, interrupt=3. dbg_slot reports the slot number, starting at 1 and never exceeding 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request, level sensitive |
| ien_set | input | 1 | One-cycle pulse that sets the interrupt enable |
| mem_rdata | input | 16 | Read data for mem_addr, valid in the read slot |
| mem_addr | output | 12 | Memory address (address latch) |
| mem_wdata | output | 16 | Memory write data (data latch) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, committed at the end of its slot |
| ien | output | 1 | Current interrupt enable |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_cyc | output | 2 | Current major cycle code |
| dbg_slot | output | 3 | Current slot number (1-based) |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction holder |
| dbg_ac | output | 16 | Accumulator |

## Verification
The increment-and-skip instruction writes its result to memory and conditionally advances PC in the same final slot. In that slot the skip decision must read the data latch already incremented, not the value fetched. The bench provokes this with operand 0xFFFF, both directly and through a pointer, so the written word wraps to zero. It judges the case by checking that the target holds 0 and that PC has moved two words past the instruction; an operand of 5 serves as the no-skip contrast. A second pairing, branch-and-save loading PC while storing the old PC, is judged by the stored return address and the final PC.

// File: rtl/uop_acc_pkg.sv
package uop_acc_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned OPC_W  = 3;
    localparam int unsigned WORD_W = 1 + OPC_W + ADDR_W;
    localparam int unsigned SLOT_W = 3;

    localparam logic [SLOT_W-1:0] SLOT_T1 = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_T2 = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] SLOT_T3 = SLOT_W'(3);
    localparam logic [SLOT_W-1:0] SLOT_T4 = SLOT_W'(4);
    localparam logic [SLOT_W-1:0] SLOT_T5 = SLOT_W'(5);

    localparam logic [OPC_W-1:0] OP_LOAD = OPC_W'(0);
    localparam logic [OPC_W-1:0] OP_ADD  = OPC_W'(1);
    localparam logic [OPC_W-1:0] OP_INCZ = OPC_W'(2);
    localparam logic [OPC_W-1:0] OP_CALL = OPC_W'(3);
    localparam logic [OPC_W-1:0] OP_STOP = OPC_W'(7);

    typedef enum logic [1:0] {
        CYC_FETCH    = 2'd0,
        CYC_INDIRECT = 2'd1,
        CYC_EXECUTE  = 2'd2,
        CYC_INTR     = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_MBR  = 2'd1,
        BUS_AC   = 2'd2
    } bus_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_INC  = 2'd1,
        ALU_PASS = 2'd2
    } alu_e;

    // one gate enable per register transfer, plus slot bookkeeping
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic mbr_from_alu;
        logic pc_inc;
        logic pc_from_ir;
        logic pc_from_routine;
        logic pc_skip_zero;
        logic ir_from_mbr;
        logic ir_addr_from_mbr;
        logic y_load;
        logic z_load;
        logic ac_from_z;
        logic ac_from_mbr;
        logic mem_rd;
        logic mem_wr;
        logic set_halt;
        logic clr_ien;
        logic last;
        cyc_e next_cyc;
        bus_e bus_sel;
        alu_e alu_op;
    } ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mbr;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] z;
        logic              ien;
        logic              halted;
    } dp_t;

    typedef struct packed {
        cyc_e              cyc;
        logic [SLOT_W-1:0] slot;
    } seq_t;

endpackage

// File: rtl/uop_alu.sv
module uop_alu
    import uop_acc_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  alu_e           op,
    input  logic [W-1:0]   bus_in,
    input  logic [W-1:0]   y_in,
    output logic [W-1:0]   res
);

    // purely combinational: one operand from the bus, the other from Y
    always_comb begin
        case (op)
            ALU_ADD: res = bus_in + y_in;
            ALU_INC: res = bus_in + W'(1);
            default: res = bus_in;
        endcase
    end

endmodule

// File: rtl/uop_decode.sv
module uop_decode
    import uop_acc_pkg::*;
(
    input  cyc_e              cyc,
    input  logic [SLOT_W-1:0] slot,
    input  logic [OPC_W-1:0]  opc,
    input  logic              ind_flag,
    input  logic              int_pending,
    output ctl_t              ctl
);

    logic fin;
    logic mem_operand;

    assign mem_operand = (opc == OP_LOAD) || (opc == OP_ADD) || (opc == OP_INCZ);

    always_comb begin
        fin           = 1'b0;
        ctl           = '0;
        ctl.next_cyc  = CYC_FETCH;
        ctl.bus_sel   = BUS_IDLE;
        ctl.alu_op    = ALU_ADD;

        case (cyc)
            CYC_FETCH: begin
                case (slot)
                    SLOT_T1: ctl.mar_from_pc = 1'b1;
                    SLOT_T2: begin
                        ctl.mbr_from_mem = 1'b1;
                        ctl.mem_rd       = 1'b1;
                        ctl.pc_inc       = 1'b1;
                    end
                    SLOT_T3: begin
                        ctl.ir_from_mbr = 1'b1;
                        ctl.last        = 1'b1;
                        ctl.next_cyc    = ind_flag ? CYC_INDIRECT : CYC_EXECUTE;
                    end
                    default: ;
                endcase
            end

            CYC_INDIRECT: begin
                case (slot)
                    SLOT_T1: ctl.mar_from_ir = 1'b1;
                    SLOT_T2: begin
                        ctl.mbr_from_mem = 1'b1;
                        ctl.mem_rd       = 1'b1;
                    end
                    SLOT_T3: begin
                        ctl.ir_addr_from_mbr = 1'b1;
                        ctl.last             = 1'b1;
                        ctl.next_cyc         = CYC_EXECUTE;
                    end
                    default: ;
                endcase
            end

            CYC_EXECUTE: begin
                // shared operand prologue for memory-reading opcodes
                if (mem_operand && slot == SLOT_T1) ctl.mar_from_ir = 1'b1;
                if (mem_operand && slot == SLOT_T2) begin
                    ctl.mbr_from_mem = 1'b1;
                    ctl.mem_rd       = 1'b1;
                end
                case (opc)
                    OP_LOAD: begin
                        if (slot == SLOT_T3) begin
                            ctl.ac_from_mbr = 1'b1;
                            fin             = 1'b1;
                        end
                    end
                    OP_ADD: begin
                        case (slot)
                            SLOT_T3: begin
                                ctl.bus_sel = BUS_MBR;
                                ctl.y_load  = 1'b1;
                            end
                            SLOT_T4: begin
                                ctl.bus_sel = BUS_AC;
                                ctl.alu_op  = ALU_ADD;
                                ctl.z_load  = 1'b1;
                            end
                            SLOT_T5: begin
                                ctl.ac_from_z = 1'b1;
                                fin           = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    OP_INCZ: begin
                        case (slot)
                            SLOT_T3: begin
                                ctl.bus_sel      = BUS_MBR;
                                ctl.alu_op       = ALU_INC;
                                ctl.mbr_from_alu = 1'b1;
                            end
                            SLOT_T4: begin
                                ctl.mem_wr       = 1'b1;
                                ctl.pc_skip_zero = 1'b1;
                                fin              = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    OP_CALL: begin
                        case (slot)
                            SLOT_T1: begin
                                ctl.mar_from_ir = 1'b1;
                                ctl.mbr_from_pc = 1'b1;
                            end
                            SLOT_T2: begin
                                ctl.pc_from_ir = 1'b1;
                                ctl.mem_wr     = 1'b1;
                            end
                            SLOT_T3: begin
                                ctl.pc_inc = 1'b1;
                                fin        = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    OP_STOP: begin
                        if (slot == SLOT_T1) ctl.set_halt = 1'b1;
                    end
                    default: begin
                        // unassigned opcode: leave execute at once
                        if (slot == SLOT_T1) fin = 1'b1;
                    end
                endcase
            end

            CYC_INTR: begin
                case (slot)
                    SLOT_T1: ctl.mbr_from_pc = 1'b1;
                    SLOT_T2: begin
                        ctl.mar_from_save   = 1'b1;
                        ctl.pc_from_routine = 1'b1;
                    end
                    SLOT_T3: begin
                        ctl.mem_wr   = 1'b1;
                        ctl.last     = 1'b1;
                        ctl.next_cyc = CYC_FETCH;
                    end
                    default: ;
                endcase
            end

            default: ;
        endcase

        // interrupt test point: only when execute finishes
        if (fin) begin
            ctl.last = 1'b1;
            if (int_pending) begin
                ctl.next_cyc = CYC_INTR;
                ctl.clr_ien  = 1'b1;
            end else begin
                ctl.next_cyc = CYC_FETCH;
            end
        end
    end

endmodule

// File: rtl/uop_seq.sv
module uop_seq
    import uop_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              last,
    input  cyc_e              next_cyc,
    output cyc_e              cyc,
    output logic [SLOT_W-1:0] slot
);

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        if (!hold) begin
            if (last) begin
                seq_d.cyc  = next_cyc;
                seq_d.slot = SLOT_T1;
            end else begin
                seq_d.slot = seq_q.slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.cyc  <= CYC_FETCH;
            seq_q.slot <= SLOT_T1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cyc  = seq_q.cyc;
    assign slot = seq_q.slot;

endmodule

// File: rtl/uop_acc_cpu.sv
module uop_acc_cpu
    import uop_acc_pkg::*;
#(
    parameter int unsigned BOOT_ADDR    = 16,
    parameter int unsigned SAVE_ADDR    = 0,
    parameter int unsigned ROUTINE_ADDR = 1,
    parameter int unsigned INSTR_LEN    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq,
    input  logic        ien_set,
    input  logic [15:0] mem_rdata,
    output logic [11:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        ien,
    output logic        halted,
    output logic [1:0]  dbg_cyc,
    output logic [2:0]  dbg_slot,
    output logic [11:0] dbg_pc,
    output logic [15:0] dbg_ir,
    output logic [15:0] dbg_ac
);

    localparam logic [ADDR_W-1:0] BOOT_A    = ADDR_W'(BOOT_ADDR);
    localparam logic [ADDR_W-1:0] SAVE_A    = ADDR_W'(SAVE_ADDR);
    localparam logic [ADDR_W-1:0] ROUTINE_A = ADDR_W'(ROUTINE_ADDR);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(INSTR_LEN);
    localparam int unsigned       OPC_LSB   = ADDR_W;
    localparam int unsigned       IND_BIT   = WORD_W - 1;

    dp_t               dp_q, dp_d;
    ctl_t              ctl_raw, ctl;
    cyc_e              cyc;
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] bus;
    logic [WORD_W-1:0] alu_res;

    uop_decode u_decode (
        .cyc         (cyc),
        .slot        (slot),
        .opc         (dp_q.ir[OPC_LSB +: OPC_W]),
        .ind_flag    (dp_q.mbr[IND_BIT]),
        .int_pending (irq & dp_q.ien),
        .ctl         (ctl_raw)
    );

    // a halted machine opens no gates
    always_comb begin
        ctl = ctl_raw;
        if (dp_q.halted) ctl = '0;
    end

    uop_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (dp_q.halted | ctl.set_halt),
        .last     (ctl.last),
        .next_cyc (ctl.next_cyc),
        .cyc      (cyc),
        .slot     (slot)
    );

    // single internal bus feeding the ALU
    always_comb begin
        case (ctl.bus_sel)
            BUS_MBR: bus = dp_q.mbr;
            BUS_AC:  bus = dp_q.ac;
            default: bus = '0;
        endcase
    end

    uop_alu #(.W(WORD_W)) u_alu (
        .op     (ctl.alu_op),
        .bus_in (bus),
        .y_in   (dp_q.y),
        .res    (alu_res)
    );

    always_comb begin
        dp_d = dp_q;

        if (ctl.mar_from_pc)   dp_d.mar = dp_q.pc;
        if (ctl.mar_from_ir)   dp_d.mar = dp_q.ir[ADDR_W-1:0];
        if (ctl.mar_from_save) dp_d.mar = SAVE_A;

        if (ctl.mbr_from_mem)  dp_d.mbr = mem_rdata;
        if (ctl.mbr_from_pc)   dp_d.mbr = {{(WORD_W-ADDR_W){1'b0}}, dp_q.pc};
        if (ctl.mbr_from_alu)  dp_d.mbr = alu_res;

        if (ctl.pc_inc)          dp_d.pc = dp_q.pc + STEP;
        if (ctl.pc_from_ir)      dp_d.pc = dp_q.ir[ADDR_W-1:0];
        if (ctl.pc_from_routine) dp_d.pc = ROUTINE_A;
        if (ctl.pc_skip_zero && dp_q.mbr == '0) dp_d.pc = dp_q.pc + STEP;

        if (ctl.ir_from_mbr)      dp_d.ir = dp_q.mbr;
        if (ctl.ir_addr_from_mbr) dp_d.ir[ADDR_W-1:0] = dp_q.mbr[ADDR_W-1:0];

        if (ctl.y_load)      dp_d.y  = bus;
        if (ctl.z_load)      dp_d.z  = alu_res;
        if (ctl.ac_from_z)   dp_d.ac = dp_q.z;
        if (ctl.ac_from_mbr) dp_d.ac = dp_q.mbr;

        if (ien_set)     dp_d.ien = 1'b1;
        if (ctl.clr_ien) dp_d.ien = 1'b0;

        if (ctl.set_halt) dp_d.halted = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q    <= '0;
            dp_q.pc <= BOOT_A;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr  = dp_q.mar;
    assign mem_wdata = dp_q.mbr;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign ien       = dp_q.ien;
    assign halted    = dp_q.halted;
    assign dbg_cyc   = cyc;
    assign dbg_slot  = slot;
    assign dbg_pc    = dp_q.pc;
    assign dbg_ir    = dp_q.ir;
    assign dbg_ac    = dp_q.ac;

endmodule

// File: rtl/uop_acc_cpu_chk.sv
module uop_acc_cpu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        ien,
    input logic        halted,
    input logic [1:0]  dbg_cyc,
    input logic [2:0]  dbg_slot,
    input logic [11:0] dbg_pc
);

    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r2_fetch_reads_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cyc == 2'd0 && dbg_slot == 3'd2) |-> (mem_rd && mem_addr == dbg_pc));

    a_r2_fetch_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cyc == 2'd0 && dbg_slot == 3'd2) |=> (dbg_pc == $past(dbg_pc) + 12'd1));

    a_r8_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(dbg_pc) && $stable(dbg_slot) && $stable(dbg_cyc)));

    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    a_r9_intr_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cyc == 2'd3 && dbg_slot == 3'd1) |-> ($past(dbg_cyc) == 2'd2));

    a_r10_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cyc == 2'd3 && dbg_slot == 3'd1) |-> !ien);

    a_r10_save_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cyc == 2'd3 && dbg_slot == 3'd3) |-> (mem_wr && mem_addr == 12'd0));

    a_r11_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_slot >= 3'd1 && dbg_slot <= 3'd5));

endmodule

bind uop_acc_cpu uop_acc_cpu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .ien      (ien),
    .halted   (halted),
    .dbg_cyc  (dbg_cyc),
    .dbg_slot (dbg_slot),
    .dbg_pc   (dbg_pc)
);

// File: tb/uop_acc_cpu_tb.sv
`timescale 1ns/1ps
module uop_acc_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        ien_set = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr, ien, halted;
    logic [1:0]  dbg_cyc;
    logic [2:0]  dbg_slot;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_ir, dbg_ac;

    logic [15:0] mem [0:1023];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];

    uop_acc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .ien_set(ien_set),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ien(ien), .halted(halted),
        .dbg_cyc(dbg_cyc), .dbg_slot(dbg_slot), .dbg_pc(dbg_pc),
        .dbg_ir(dbg_ir), .dbg_ac(dbg_ac)
    );

    // instr, ptr @0x40, val @0x80, acinit @0x81, exp_ac, exp_pc, target, exp_mem, exp_slots
    typedef struct packed {
        logic [15:0] instr;
        logic [15:0] ptr;
        logic [15:0] val;
        logic [15:0] acinit;
        logic [15:0] exp_ac;
        logic [11:0] exp_pc;
        logic [11:0] tgt;
        logic [15:0] exp_mem;
        logic [7:0]  exp_slots;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0080, 16'h0000, 16'h1234, 16'h0F0F, 16'h1234, 12'h012, 12'h080, 16'h1234, 8'd6},
        '{16'h8040, 16'h0080, 16'hBEEF, 16'h0001, 16'hBEEF, 12'h012, 12'h080, 16'hBEEF, 8'd9},
        '{16'h1080, 16'h0000, 16'h1234, 16'h7000, 16'h8234, 12'h012, 12'h080, 16'h1234, 8'd8},
        '{16'h1080, 16'h0000, 16'h0002, 16'hFFFF, 16'h0001, 12'h012, 12'h080, 16'h0002, 8'd8},
        '{16'h9040, 16'h0080, 16'h0010, 16'h0020, 16'h0030, 12'h012, 12'h080, 16'h0010, 8'd11},
        '{16'h2080, 16'h0000, 16'h0005, 16'h0F0F, 16'h0F0F, 12'h012, 12'h080, 16'h0006, 8'd7},
        '{16'h2080, 16'h0000, 16'hFFFF, 16'h0F0F, 16'h0F0F, 12'h013, 12'h080, 16'h0000, 8'd7},
        '{16'hA040, 16'h0080, 16'hFFFF, 16'h0F0F, 16'h0F0F, 12'h013, 12'h080, 16'h0000, 8'd10},
        '{16'h3200, 16'h0000, 16'h0000, 16'h0F0F, 16'h0F0F, 12'h201, 12'h200, 16'h0012, 8'd6},
        '{16'h5080, 16'h0000, 16'h1234, 16'h0F0F, 16'h0F0F, 12'h012, 12'h080, 16'h1234, 8'd4},
        '{16'hB040, 16'h0200, 16'h0000, 16'h0F0F, 16'h0F0F, 12'h201, 12'h200, 16'h0012, 8'd9}
    };

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one slot: capture this slot's write, let the edge pass, apply it
    task automatic step();
        logic        w;
        logic [9:0]  a;
        logic [15:0] d;
        w = mem_wr;
        a = mem_addr[9:0];
        d = mem_wdata;
        @(posedge clk);
        if (w) mem[a] = d;
        #1;
    endtask

    task automatic start_reset();
        rst_n   = 1'b0;
        irq     = 1'b0;
        ien_set = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        step();
        step();
    endtask

    function automatic string tag_of(logic [15:0] w);
        string s;
        case (w[14:12])
            3'd0:    s = "R4";
            3'd1:    s = "R5";
            3'd2:    s = "R6";
            3'd3:    s = "R7";
            default: s = "R8";
        endcase
        if (w[15]) s = {s, "/R3"};
        return s;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // ---------------- vector table ----------------
        for (int v = 0; v < NV; v++) begin
            int    n;
            string t;
            t = tag_of(VECS[v].instr);
            start_reset();
            mem[16]   = 16'h0081;
            mem[17]   = VECS[v].instr;
            mem[16'h40] = VECS[v].ptr;
            mem[16'h80] = VECS[v].val;
            mem[16'h81] = VECS[v].acinit;
            rst_n = 1'b1;
            for (int k = 0; k < 40; k++) begin
                step();
                if (dbg_cyc == 2'd0 && dbg_slot == 3'd1) break;
            end
            n = 0;
            for (int k = 0; k < 40; k++) begin
                step();
                n++;
                if ((dbg_cyc == 2'd0 && dbg_slot == 3'd1) || halted) break;
            end
            chk(t, $sformatf("vec%0d slot count", v), 32'(n), 32'(VECS[v].exp_slots));
            chk(t, $sformatf("vec%0d AC", v), 32'(dbg_ac), 32'(VECS[v].exp_ac));
            chk(t, $sformatf("vec%0d PC", v), 32'(dbg_pc), 32'(VECS[v].exp_pc));
            chk(t, $sformatf("vec%0d memory", v), 32'(mem[VECS[v].tgt[9:0]]), 32'(VECS[v].exp_mem));
        end

        // ---------------- R1 reset state ----------------
        start_reset();
        chk("R1", "cycle", 32'(dbg_cyc), 32'd0);
        chk("R1", "slot", 32'(dbg_slot), 32'd1);
        chk("R1", "PC", 32'(dbg_pc), 32'd16);
        chk("R1", "AC", 32'(dbg_ac), 32'd0);
        chk("R1", "enable/halted", {30'd0, ien, halted}, 32'd0);
        chk("R1", "strobes", {30'd0, mem_rd, mem_wr}, 32'd0);

        // ---------------- R2 / R11 fetch trace ----------------
        start_reset();
        mem[16] = 16'h0081;
        rst_n = 1'b1;
        step();
        chk("R11", "slot after t1", 32'(dbg_slot), 32'd2);
        chk("R2", "read strobe at t2", 32'(mem_rd), 32'd1);
        chk("R2", "address at t2", 32'(mem_addr), 32'd16);
        step();
        chk("R2", "PC after t2", 32'(dbg_pc), 32'd17);
        step();
        chk("R2", "IR after t3", 32'(dbg_ir), 32'h0081);
        chk("R11", "direct goes to execute", 32'(dbg_cyc), 32'd2);

        // ---------------- R3 indirect address replacement ----------------
        start_reset();
        mem[16]     = 16'h8040;
        mem[16'h40] = 16'hF123;
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) step();
        chk("R3", "indirect cycle entered", 32'(dbg_cyc), 32'd1);
        for (int k = 0; k < 3; k++) step();
        chk("R3", "execute after indirect", 32'(dbg_cyc), 32'd2);
        chk("R3", "IR with pointer address", 32'(dbg_ir), 32'h8123);

        // ---------------- R9 / R10 interrupt entry ----------------
        start_reset();
        mem[16]     = 16'h0081;
        mem[16'h81] = 16'h5555;
        mem[0]      = 16'hDEAD;
        rst_n   = 1'b1;
        ien_set = 1'b1;
        irq     = 1'b1;
        step();
        ien_set = 1'b0;
        chk("R10", "enable set by pulse", 32'(ien), 32'd1);
        step();
        step();
        chk("R9", "no interrupt during fetch", 32'(dbg_cyc), 32'd2);
        step();
        step();
        step();
        chk("R9", "interrupt after execute", 32'(dbg_cyc), 32'd3);
        chk("R10", "enable cleared on entry", 32'(ien), 32'd0);
        chk("R4", "load before interrupt", 32'(dbg_ac), 32'h5555);
        step();
        step();
        chk("R10", "save write strobe", 32'(mem_wr), 32'd1);
        chk("R10", "save address", 32'(mem_addr), 32'd0);
        chk("R10", "saved value", 32'(mem_wdata), 32'd17);
        step();
        irq = 1'b0;
        chk("R10", "PC at routine", 32'(dbg_pc), 32'd1);
        chk("R10", "memory at save address", 32'(mem[0]), 32'd17);
        chk("R11", "back to fetch", {27'd0, dbg_cyc, dbg_slot}, {27'd0, 2'd0, 3'd1});

        // ---------------- R9 request without enable ----------------
        start_reset();
        mem[16] = 16'h0081;
        rst_n = 1'b1;
        irq   = 1'b1;
        for (int k = 0; k < 6; k++) step();
        chk("R9", "disabled irq ignored, cycle", 32'(dbg_cyc), 32'd0);
        chk("R9", "disabled irq ignored, PC", 32'(dbg_pc), 32'd17);
        irq = 1'b0;

        // ---------------- R8 halt ----------------
        start_reset();
        mem[16] = 16'h7000;
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) step();
        chk("R8", "halted set", 32'(halted), 32'd1);
        for (int k = 0; k < 5; k++) step();
        chk("R8", "PC frozen", 32'(dbg_pc), 32'd17);
        chk("R8", "cycle/slot frozen", {27'd0, dbg_cyc, dbg_slot}, {27'd0, 2'd2, 3'd1});
        chk("R8", "no strobes", {30'd0, mem_rd, mem_wr}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule